// File: doc/BRIEF.md
# Per-Trigger Confirmation and Veto Evaluator

This block forms a second-stage decision for up to sixteen triggers that have already fired in a first-stage decision and that need confirmation from slower processing. Thirty-two confirmation terms each report a done flag and an answer. For every trigger a programmable mask names the terms that trigger requires. A trigger is confirmed when every required term has reported done with an accept answer. It is vetoed as soon as any required term reports done with a reject answer. Terms outside a trigger's mask have no effect on that trigger.

A confirmation cycle opens on a start strobe. The strobe loads the set of fired triggers and clears the per-term done and answer memory. Term reports are gathered into sticky registers, so a done pulse that drops again before the decision is not lost. A close strobe freezes that memory, which holds the confirm and veto bits steady until the next start so that downstream logic can latch them. Two summary flags are also produced: one says that at least one trigger is confirmed, and the other says that every fired trigger is vetoed.

Top module: `confirm_veto_eval`

## Requirements
- R1: A write with `mask_wr_en` high stores `mask_wr_data` as the required-term mask of trigger `mask_wr_idx` (bit k set means term k is required). The new mask takes effect from the following clock edge. All masks reset to zero.
- R2: `confirm[i]` is high when trigger i is in the fired set and every term required by its mask has been seen done with answer 1 (accept) in the current cycle. Terms that are not required are ignored.
- R3: `veto[i]` is high when trigger i is in the fired set and at least one term required by its mask has been seen done with answer 0 (reject) in the current cycle.
- R4: After reset, and for any trigger not in the fired set, `confirm` and `veto` are 0.
- R5: A term's answer is recorded only on the first clock edge of a cycle at which its done bit is high. The done bit stays recorded after the input drops, and later changes of that term's answer within the cycle are ignored.
- R6: After the clock edge at which `cyc_end` is high, further term inputs are ignored and `confirm`/`veto` hold their values until the next `cyc_start`.
- R7: On a `cyc_start` edge, `fired_in` is loaded as the fired set, all recorded done and answer state is cleared, and term inputs present in that same cycle are ignored. If `cyc_start` and `cyc_end` are both high, the start takes priority.
- R8: A fired trigger whose mask is all zero is confirmed from the clock edge of `cyc_start` onward.
- R9: `any_confirmed` is the OR of all `confirm` bits.
- R10: `all_vetoed` is high exactly when the fired set is non-empty and every fired trigger has its veto bit set.
- R11: A term report at the inputs is reflected in `confirm`/`veto` after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Opens a confirmation cycle and loads the fired set |
| cyc_end | input | 1 | Closes the cycle and freezes the term state |
| fired_in | input | 16 | Triggers that fired, sampled at cycle start |
| term_done | input | 32 | Per-term done flags |
| term_answer | input | 32 | Per-term answer, 1 = accept, 0 = reject |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_idx | input | 4 | Trigger whose mask is written |
| mask_wr_data | input | 32 | Required-term mask value |
| confirm | output | 16 | Per-trigger confirmation |
| veto | output | 16 | Per-trigger veto |
| any_confirmed | output | 1 | At least one trigger confirmed |
| all_vetoed | output | 1 | Fired set non-empty and fully vetoed |

## Verification
Every result comes from registers that update at one clock edge and from combinational logic after them. A start strobe, a term report, a close strobe or a mask write is therefore visible at the outputs one edge after it is driven. The bench drives inputs on the falling edge and updates its own model at the next rising edge using the values it drove. It then compares all four outputs at the following falling edge, so each comparison sits one edge after its stimulus. Directed sequences also check fixed constants at these same points for first-done capture, late answer changes, terms seen in the start cycle, reports after the close strobe, and zero-mask triggers.

// File: rtl/cve_pkg.sv
package cve_pkg;

    parameter int unsigned TRIG_N_DEF = 16;
    parameter int unsigned TERM_N_DEF = 32;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_OPEN = 1'b1
    } cyc_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
    } cyc_ctrl_t;

endpackage

// File: rtl/cve_cycle_ctrl.sv
module cve_cycle_ctrl
    import cve_pkg::*;
#(
    parameter int unsigned TRIG_N = TRIG_N_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_ctrl_t         ctrl,
    input  logic [TRIG_N-1:0] fired_in,
    output logic [TRIG_N-1:0] fired_q,
    output logic              capture_en,
    output logic              clear
);

    cyc_phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            fired_q <= '0;
        end else if (ctrl.start) begin
            phase_q <= PH_OPEN;
            fired_q <= fired_in;
        end else if (ctrl.stop) begin
            phase_q <= PH_IDLE;
        end
    end

    always_comb begin
        clear      = ctrl.start;
        capture_en = (phase_q == PH_OPEN) && !ctrl.start;
    end

    p_fired_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !ctrl.start |=> $stable(fired_q));

endmodule

// File: rtl/cve_term_latch.sv
module cve_term_latch #(
    parameter int unsigned TERM_N = cve_pkg::TERM_N_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              capture_en,
    input  logic [TERM_N-1:0] done_in,
    input  logic [TERM_N-1:0] answer_in,
    output logic [TERM_N-1:0] done_s,
    output logic [TERM_N-1:0] accept_s
);

    logic [TERM_N-1:0] first_seen;

    always_comb first_seen = done_in & ~done_s;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            done_s   <= '0;
            accept_s <= '0;
        end else if (capture_en) begin
            done_s   <= done_s | done_in;
            accept_s <= (accept_s & done_s) | (first_seen & answer_in);
        end
    end

    p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((done_s & $past(done_s)) == $past(done_s)));

    p_answer_kept_r5: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((accept_s & $past(done_s)) == ($past(accept_s) & $past(done_s))));

    p_start_clears_r7: assert property (@(posedge clk) disable iff (rst)
        clear |=> (done_s == '0 && accept_s == '0));

endmodule

// File: rtl/cve_mask_bank.sv
module cve_mask_bank #(
    parameter int unsigned TRIG_N = cve_pkg::TRIG_N_DEF,
    parameter int unsigned TERM_N = cve_pkg::TERM_N_DEF,
    localparam int unsigned IDX_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [TERM_N-1:0]             wr_data,
    output logic [TRIG_N-1:0][TERM_N-1:0] masks
);

    for (genvar g = 0; g < TRIG_N; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                masks[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                masks[g] <= wr_data;
            end
        end
    end

    p_mask_write_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (32'(wr_idx) < TRIG_N)) |=> (masks[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/cve_trig_eval.sv
module cve_trig_eval #(
    parameter int unsigned TERM_N = cve_pkg::TERM_N_DEF
) (
    input  logic              fired,
    input  logic [TERM_N-1:0] required,
    input  logic [TERM_N-1:0] done_s,
    input  logic [TERM_N-1:0] accept_s,
    output logic              confirm,
    output logic              veto
);

    logic [TERM_N-1:0] missing;
    logic [TERM_N-1:0] rejected;

    always_comb begin
        missing  = required & ~(done_s & accept_s);
        rejected = required & done_s & ~accept_s;
        confirm  = fired && (missing == '0);
        veto     = fired && (rejected != '0);
    end

endmodule

// File: rtl/confirm_veto_eval.sv
module confirm_veto_eval
    import cve_pkg::*;
#(
    parameter int unsigned TRIG_N = TRIG_N_DEF,
    parameter int unsigned TERM_N = TERM_N_DEF,
    localparam int unsigned IDX_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  logic [TRIG_N-1:0] fired_in,
    input  logic [TERM_N-1:0] term_done,
    input  logic [TERM_N-1:0] term_answer,
    input  logic              mask_wr_en,
    input  logic [IDX_W-1:0]  mask_wr_idx,
    input  logic [TERM_N-1:0] mask_wr_data,
    output logic [TRIG_N-1:0] confirm,
    output logic [TRIG_N-1:0] veto,
    output logic              any_confirmed,
    output logic              all_vetoed
);

    cyc_ctrl_t                  ctrl;
    logic [TRIG_N-1:0]          fired_q;
    logic                       capture_en;
    logic                       clear;
    logic [TERM_N-1:0]          done_s;
    logic [TERM_N-1:0]          accept_s;
    logic [TRIG_N-1:0][TERM_N-1:0] masks;

    always_comb begin
        ctrl.start = cyc_start;
        ctrl.stop  = cyc_end;
    end

    cve_cycle_ctrl #(.TRIG_N(TRIG_N)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .fired_in   (fired_in),
        .fired_q    (fired_q),
        .capture_en (capture_en),
        .clear      (clear)
    );

    cve_term_latch #(.TERM_N(TERM_N)) u_terms (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .capture_en (capture_en),
        .done_in    (term_done),
        .answer_in  (term_answer),
        .done_s     (done_s),
        .accept_s   (accept_s)
    );

    cve_mask_bank #(.TRIG_N(TRIG_N), .TERM_N(TERM_N)) u_masks (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mask_wr_en),
        .wr_idx  (mask_wr_idx),
        .wr_data (mask_wr_data),
        .masks   (masks)
    );

    for (genvar t = 0; t < TRIG_N; t++) begin : g_trig
        cve_trig_eval #(.TERM_N(TERM_N)) u_eval (
            .fired    (fired_q[t]),
            .required (masks[t]),
            .done_s   (done_s),
            .accept_s (accept_s),
            .confirm  (confirm[t]),
            .veto     (veto[t])
        );
    end

    always_comb begin
        any_confirmed = |confirm;
        all_vetoed    = (fired_q != '0) && ((fired_q & ~veto) == '0);
    end

    p_unfired_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        ((confirm | veto) & ~fired_q) == '0);

    p_no_dual_outcome_r2: assert property (@(posedge clk) disable iff (rst)
        (confirm & veto) == '0);

    p_hold_after_end_r6: assert property (@(posedge clk) disable iff (rst)
        (!capture_en && !cyc_start && !mask_wr_en) |=> ($stable(confirm) && $stable(veto)));

    p_all_vetoed_r10: assert property (@(posedge clk) disable iff (rst)
        all_vetoed |-> (!any_confirmed && veto == fired_q));

    p_any_confirmed_r9: assert property (@(posedge clk) disable iff (rst)
        any_confirmed |-> (confirm != '0));

endmodule

// File: tb/test_confirm_veto_eval.sv
module test_confirm_veto_eval;

    localparam int TRIG_N = 16;
    localparam int TERM_N = 32;
    localparam int IDX_W  = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              cyc_start, cyc_end;
    logic [TRIG_N-1:0] fired_in;
    logic [TERM_N-1:0] term_done, term_answer;
    logic              mask_wr_en;
    logic [IDX_W-1:0]  mask_wr_idx;
    logic [TERM_N-1:0] mask_wr_data;
    logic [TRIG_N-1:0] confirm, veto;
    logic              any_confirmed, all_vetoed;

    always #2 clk = ~clk;

    confirm_veto_eval i_confirm_veto_eval (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_end(cyc_end),
        .fired_in(fired_in), .term_done(term_done), .term_answer(term_answer),
        .mask_wr_en(mask_wr_en), .mask_wr_idx(mask_wr_idx), .mask_wr_data(mask_wr_data),
        .confirm(confirm), .veto(veto), .any_confirmed(any_confirmed), .all_vetoed(all_vetoed)
    );

    // Bench model built from the requirements
    logic [TERM_N-1:0] m_mask [TRIG_N];
    logic [TRIG_N-1:0] m_fired;
    logic [TERM_N-1:0] m_done, m_acc;
    logic              m_open;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [31:0] lfsr = 32'h1ACE_2B3D;

    function automatic logic [31:0] rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        logic [TERM_N-1:0] fresh;
        if (rst) begin
            for (int i = 0; i < TRIG_N; i++) m_mask[i] = '0;
            m_fired = '0; m_done = '0; m_acc = '0; m_open = 1'b0;
        end else begin
            if (mask_wr_en) m_mask[mask_wr_idx] = mask_wr_data;
            if (cyc_start) begin
                m_fired = fired_in; m_done = '0; m_acc = '0; m_open = 1'b1;
            end else begin
                if (m_open) begin
                    fresh  = term_done & ~m_done;
                    m_acc  = (m_acc & m_done) | (fresh & term_answer);
                    m_done = m_done | term_done;
                end
                if (cyc_end) m_open = 1'b0;
            end
        end
    endtask

    task automatic compare_all();
        logic [TRIG_N-1:0] ec, ev;
        for (int i = 0; i < TRIG_N; i++) begin
            ec[i] = m_fired[i] && ((m_mask[i] & ~(m_done & m_acc)) == '0);
            ev[i] = m_fired[i] && ((m_mask[i] & m_done & ~m_acc) != '0);
        end
        chk("R2 confirm", 32'(confirm), 32'(ec));
        chk("R3 veto", 32'(veto), 32'(ev));
        chk("R9 any_confirmed", 32'(any_confirmed), 32'(ec != '0));
        chk("R10 all_vetoed", 32'(all_vetoed), 32'((m_fired != '0) && ((m_fired & ~ev) == '0)));
    endtask

    // Inputs are driven at the falling edge; one rising edge, then sample.
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        cyc_start = 0; cyc_end = 0; fired_in = '0;
        term_done = '0; term_answer = '0;
        mask_wr_en = 0; mask_wr_idx = '0; mask_wr_data = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below 200000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        @(negedge clk);
        step();
        step();
        rst = 0;
        // R4: reset state
        chk("R4 confirm after reset", 32'(confirm), 32'h0);
        chk("R4 veto after reset", 32'(veto), 32'h0);
        chk("R10 all_vetoed after reset", 32'(all_vetoed), 32'h0);

        // R1: program masks
        for (int i = 0; i < TRIG_N; i++) begin
            mask_wr_en = 1; mask_wr_idx = IDX_W'(i);
            if (i == 0)      mask_wr_data = '0;
            else if (i == 3) mask_wr_data = 32'h0000_0005;
            else mask_wr_data = (32'h1 << i) | (32'h1 << ((i * 5 + 3) % 32)) |
                                ((i >= 8) ? (32'h1 << (i + 16)) : 32'h0);
            step();
        end
        mask_wr_en = 0;

        // Directed: trigger 3 requires terms 0 and 2
        cyc_start = 1; fired_in = 16'h0008;
        term_done = 32'h5; term_answer = 32'h5;   // R7: ignored in start cycle
        step();
        cyc_start = 0; fired_in = '0;
        chk("R7 start-cycle terms ignored", 32'(confirm), 32'h0);
        term_done = 32'h3; term_answer = 32'h1;   // term0 accept, term1 reject (not required)
        step();
        chk("R1 unrequired reject ignored", 32'(veto), 32'h0);
        chk("R2 partial not confirmed", 32'(confirm), 32'h0);
        term_done = 32'h4; term_answer = 32'h4;   // term0 dropped, term2 accepts
        step();
        chk("R11 confirm one edge later", 32'(confirm), 32'h0008);
        chk("R5 dropped done remembered", 32'(any_confirmed), 32'h1);
        term_done = 32'h5; term_answer = 32'h0;   // late rejects
        step();
        chk("R5 late answer ignored", 32'(veto), 32'h0);
        cyc_end = 1; term_done = '0;
        step();
        cyc_end = 0;
        term_done = '1; term_answer = '0;
        step();
        step();
        chk("R6 held after end", 32'(confirm), 32'h0008);
        chk("R6 no veto after end", 32'(veto), 32'h0);

        // R8 with zero mask, then R3/R10
        cyc_start = 1; fired_in = 16'h0009; term_done = '0;
        step();
        cyc_start = 0;
        chk("R8 zero mask confirms at start", 32'(confirm), 32'h0001);
        term_done = 32'h1; term_answer = 32'h0;
        step();
        chk("R3 reject vetoes", 32'(veto), 32'h0008);
        chk("R10 not all vetoed", 32'(all_vetoed), 32'h0);
        cyc_start = 1; fired_in = 16'h0008; term_done = '0;
        step();
        cyc_start = 0;
        term_done = 32'h4; term_answer = 32'h0;
        step();
        chk("R10 all vetoed", 32'(all_vetoed), 32'h1);
        chk("R9 none confirmed", 32'(any_confirmed), 32'h0);
        cyc_start = 1; cyc_end = 1; fired_in = 16'h0001; term_done = '0;
        step();
        cyc_start = 0; cyc_end = 0;
        term_done = 32'h4; term_answer = 32'h0;
        step();
        chk("R7 start wins over end", 32'(confirm), 32'h0001);

        // Sweep of pseudo-random cycles against the model
        for (int c = 0; c < 120; c++) begin
            term_done = '0;
            cyc_start = 1; fired_in = rnd()[TRIG_N-1:0];
            step();
            cyc_start = 0;
            for (int s = 0; s < 4 + (c % 5); s++) begin
                term_done   = rnd() & rnd();
                term_answer = (c % 3 == 0) ? '1 : rnd() | rnd();
                mask_wr_en  = (rnd() % 8) == 0;
                mask_wr_idx = IDX_W'(rnd());
                mask_wr_data = rnd() & rnd() & rnd();
                step();
                mask_wr_en = 0;
            end
            cyc_end = 1;
            step();
            cyc_end = 0;
            for (int h = 0; h < 2; h++) begin
                term_done = rnd(); term_answer = rnd();
                step();
            end
        end

        finish_run();
    end

endmodule